// File: doc/BRIEF.md
# Pending Interrupt Arbiter with Acknowledge

This block picks the most urgent pending interrupt for one processor and answers that processor's acknowledge reads. The ID space is reduced. IDs 0 to 31 are private to the processor: 0–15 are software-generated and 16–31 are per-processor peripheral lines. Shared interrupts follow from ID 32, and their number is set by a parameter. The block holds the pending, active and signalled flags of every ID. Enable, trigger, group, target, handling-model and priority settings come from the surrounding register logic as plain input vectors, and the current running priority comes from a separate priority tracker.

A scanner visits one ID per clock, so a full pass takes one cycle per ID. It keeps the best candidate seen so far and publishes the winner at the end of each pass. An acknowledge request waits until the end of the pass that is in progress and is then resolved against that pass's winner. The result is the winning ID, or one of two special IDs when the acknowledge is not permitted. A granted acknowledge makes the winner active and signalled, and sends a one-cycle notice to the priority tracker.

Top module: `irqarb_top`

## Requirements
- R1: IDs 0–31 always target this processor. An ID of 32 or more is a shared interrupt and is a candidate only while its bit `spi_target[id-32]` is 1. IDs are returned in a 10-bit field.
- R2: An ID is a candidate only when its enable bit is 1, it is pending, and it is not active.
- R3: An ID is pending when its pending latch is set. An ID whose `irq_edge` bit is 0 (level mode) is also pending while its `irq_level` input is 1 and its signalled flag is clear. In edge mode (`irq_edge`=1) the level input alone never makes an ID pending.
- R4: The candidate with the numerically lowest priority value wins, and equal priorities go to the lowest ID. A priority of all ones never wins. With no candidate the result is ID 1023 with priority all ones. `hp_id` and `hp_prio` show the winner of the last completed pass.
- R5: An acknowledge returns 1023 when the winner's group is disabled in `cpu_grp_en` or in `dist_grp_en` (bit 0 enables group 0, bit 1 enables group 1). It also returns 1023 for a group-0 winner when `sec_en`=1 and `ack_secure`=0.
- R6: Once R5 has passed, a non-alias (`ack_alias`=0) acknowledge of a group-1 winner returns 1022 when `sec_en`=1, `ack_secure`=1 and `ack_ackctl`=0.
- R7: Once R5 and R6 have passed, an acknowledge returns 1023 when the winner's priority is greater than or equal to `run_prio`.
- R8: Any other acknowledge returns the winner's ID. In the cycle in which `ack_valid` rises, the winner becomes active and signalled and its pending latch is cleared.
- R9: A granted acknowledge raises `trk_valid` for one cycle together with `ack_valid`, carrying the ID, its priority, and `trk_all`. `trk_all` equals `spi_one_of_n[id-32]` for shared IDs and 0 for private IDs. A special ID never raises `trk_valid`.
- R10: An acknowledge request is accepted only at the last step of a pass. `ack_valid` pulses for exactly one cycle, one cycle after acceptance, and passes repeat every NUM_SPI+32 cycles.
- R11: A `deact` pulse clears the active and signalled flags of its IDs. A `pend_clr` pulse clears pending latches, and a `pend_set` pulse in the same cycle overrides it.
- R12: After reset all pending, active and signalled flags are clear, `hp_id` is 1023, `hp_prio` is all ones, and no acknowledge or tracker pulse is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_en | input | NUM_SPI+32 | Per-ID enable |
| irq_edge | input | NUM_SPI+32 | Per-ID trigger: 1 edge, 0 level |
| irq_group | input | NUM_SPI+32 | Per-ID group (0 or 1) |
| irq_level | input | NUM_SPI+32 | Per-ID input line level |
| spi_target | input | NUM_SPI | Shared-ID target bit for this processor |
| spi_one_of_n | input | NUM_SPI | Shared-ID 1-of-N handling model |
| irq_prio | input | (NUM_SPI+32)*PRIO_W | Per-ID priority, ID i in bits [i*PRIO_W +: PRIO_W] |
| pend_set | input | NUM_SPI+32 | Pulse: set pending latches |
| pend_clr | input | NUM_SPI+32 | Pulse: clear pending latches |
| deact | input | NUM_SPI+32 | Pulse: clear active and signalled |
| cpu_grp_en | input | 2 | Processor-side group enables |
| dist_grp_en | input | 2 | Distributor-side group enables |
| sec_en | input | 1 | Security extensions enabled |
| ack_ackctl | input | 1 | Secure non-alias acknowledge of group 1 allowed |
| run_prio | input | PRIO_W | Running priority from the tracker |
| ack_req | input | 1 | Acknowledge request, held until ack_valid |
| ack_alias | input | 1 | Request uses the alias view |
| ack_secure | input | 1 | Request is a secure access |
| ack_valid | output | 1 | Acknowledge result strobe |
| ack_id | output | 10 | Acknowledged or special ID |
| hp_id | output | 10 | Highest pending ID of the last pass |
| hp_prio | output | PRIO_W | Its priority |
| trk_valid | output | 1 | Grant notice to the priority tracker |
| trk_id | output | 10 | Granted ID |
| trk_prio | output | PRIO_W | Granted priority |
| trk_all | output | 1 | Grant applies to all processors |

## Verification
The assertions assume a well-behaved requester. It holds `ack_req` until it sees `ack_valid` and drops it within one pass. They also assume `run_prio` changes only between acknowledges, so the grant check against the previous cycle's running priority holds. The stimulus follows the same discipline. After every change to levels, configuration or latches it waits a full pass plus a few cycles before requesting, so the pass that resolves an acknowledge has seen steady state. It drives pulses for exactly one cycle, and it releases the request on the first cycle in which `ack_valid` is seen.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
   localparam int ID_W        = 10;
   localparam int NUM_PRIV    = 32;
   localparam int MAX_SHARED  = 988;
   localparam logic [ID_W-1:0] ID_NONE    = 10'd1023;
   localparam logic [ID_W-1:0] ID_BLOCKED = 10'd1022;

   typedef enum logic [1:0] {
      ACK_GRANT    = 2'd0,
      ACK_SPURIOUS = 2'd1,
      ACK_BLOCKED  = 2'd2
   } ack_kind_e;
endpackage

// File: rtl/irqarb_state_bank.sv
module irqarb_state_bank
   import irqarb_pkg::*;
#(
   parameter int NUM_SPI = 32,
   localparam int NUM_IRQ = NUM_SPI + NUM_PRIV
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic [NUM_IRQ-1:0] irq_edge,
   input  logic [NUM_IRQ-1:0] irq_level,
   input  logic [NUM_SPI-1:0] spi_target,
   input  logic [NUM_IRQ-1:0] pend_set,
   input  logic [NUM_IRQ-1:0] pend_clr,
   input  logic [NUM_IRQ-1:0] deact,
   input  logic [NUM_IRQ-1:0] grant_mask,
   output logic [NUM_IRQ-1:0] cand,
   output logic [NUM_IRQ-1:0] active
);
   logic [NUM_IRQ-1:0] pend_q, act_q, sig_q, tgt_ok, eff_pend;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
      if (i < NUM_PRIV) begin : g_priv
         assign tgt_ok[i] = 1'b1;
      end else begin : g_shared
         assign tgt_ok[i] = spi_target[i-NUM_PRIV];
      end
      assign eff_pend[i] = pend_q[i] | (~irq_edge[i] & irq_level[i] & ~sig_q[i]);
      assign cand[i]     = irq_en[i] & eff_pend[i] & ~act_q[i] & tgt_ok[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
         sig_q  <= '0;
      end else begin
         pend_q <= (pend_q & ~pend_clr & ~grant_mask) | pend_set;
         act_q  <= (act_q & ~deact) | grant_mask;
         sig_q  <= (sig_q & ~deact) | grant_mask;
      end
   end

   assign active = act_q;
endmodule

// File: rtl/irqarb_scan.sv
module irqarb_scan
   import irqarb_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int PRIO_W  = 8,
   localparam int IDX_W  = $clog2(NUM_IRQ)
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ-1:0]        cand,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
   output logic                      last,
   output logic                      fin_found,
   output logic [IDX_W-1:0]          fin_idx,
   output logic [PRIO_W-1:0]         fin_prio,
   output logic [ID_W-1:0]           hp_id,
   output logic [PRIO_W-1:0]         hp_prio
);
   logic [IDX_W-1:0]  idx_q, run_idx, base_idx;
   logic              run_found, base_found, first, take;
   logic [PRIO_W-1:0] run_prio_q, base_prio, cur_prio;

   assign first    = (idx_q == '0);
   assign last     = (idx_q == IDX_W'(NUM_IRQ - 1));
   assign cur_prio = prio_flat[int'(idx_q)*PRIO_W +: PRIO_W];

   always_comb begin
      base_found = first ? 1'b0 : run_found;
      base_idx   = first ? '0   : run_idx;
      base_prio  = first ? '1   : run_prio_q;
      // strict compare: earlier (lower) ID keeps a tie
      take       = cand[idx_q] && (cur_prio < base_prio);
      fin_found  = take ? 1'b1     : base_found;
      fin_idx    = take ? idx_q    : base_idx;
      fin_prio   = take ? cur_prio : base_prio;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q      <= '0;
         run_found  <= 1'b0;
         run_idx    <= '0;
         run_prio_q <= '1;
         hp_id      <= ID_NONE;
         hp_prio    <= '1;
      end else begin
         idx_q      <= last ? '0 : idx_q + 1'b1;
         run_found  <= fin_found;
         run_idx    <= fin_idx;
         run_prio_q <= fin_prio;
         if (last) begin
            hp_id   <= fin_found ? ID_W'(fin_idx) : ID_NONE;
            hp_prio <= fin_prio;
         end
      end
   end
endmodule

// File: rtl/irqarb_ack_resolve.sv
module irqarb_ack_resolve
   import irqarb_pkg::*;
#(
   parameter int PRIO_W = 8
)(
   input  logic              found,
   input  logic              grp,
   input  logic [PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0] run_prio,
   input  logic [1:0]        cpu_grp_en,
   input  logic [1:0]        dist_grp_en,
   input  logic              sec_en,
   input  logic              acc_secure,
   input  logic              alias_view,
   input  logic              ackctl,
   output ack_kind_e         kind
);
   logic grp_ok;

   always_comb begin
      if (grp)
         grp_ok = cpu_grp_en[1] & dist_grp_en[1];
      else
         grp_ok = cpu_grp_en[0] & dist_grp_en[0] & (~sec_en | acc_secure);

      if (!found || !grp_ok)
         kind = ACK_SPURIOUS;
      else if (!alias_view && grp && !ackctl && sec_en && acc_secure)
         kind = ACK_BLOCKED;
      else if (prio >= run_prio)
         kind = ACK_SPURIOUS;
      else
         kind = ACK_GRANT;
   end
endmodule

// File: rtl/irqarb_top.sv
module irqarb_top
   import irqarb_pkg::*;
#(
   parameter int NUM_SPI = 32,
   parameter int PRIO_W  = 8,
   localparam int NUM_IRQ = NUM_SPI + NUM_PRIV
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ-1:0]        irq_en,
   input  logic [NUM_IRQ-1:0]        irq_edge,
   input  logic [NUM_IRQ-1:0]        irq_group,
   input  logic [NUM_IRQ-1:0]        irq_level,
   input  logic [NUM_SPI-1:0]        spi_target,
   input  logic [NUM_SPI-1:0]        spi_one_of_n,
   input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
   input  logic [NUM_IRQ-1:0]        pend_set,
   input  logic [NUM_IRQ-1:0]        pend_clr,
   input  logic [NUM_IRQ-1:0]        deact,
   input  logic [1:0]                cpu_grp_en,
   input  logic [1:0]                dist_grp_en,
   input  logic                      sec_en,
   input  logic                      ack_ackctl,
   input  logic [PRIO_W-1:0]         run_prio,
   input  logic                      ack_req,
   input  logic                      ack_alias,
   input  logic                      ack_secure,
   output logic                      ack_valid,
   output logic [ID_W-1:0]           ack_id,
   output logic [ID_W-1:0]           hp_id,
   output logic [PRIO_W-1:0]         hp_prio,
   output logic                      trk_valid,
   output logic [ID_W-1:0]           trk_id,
   output logic [PRIO_W-1:0]         trk_prio,
   output logic                      trk_all
);
   localparam int IDX_W = $clog2(NUM_IRQ);

   if (NUM_SPI < 1 || NUM_SPI > MAX_SHARED) begin : g_bad_spi
      $error("irqarb_top: NUM_SPI out of range");
   end
   if (PRIO_W < 4 || PRIO_W > 8) begin : g_bad_prio
      $error("irqarb_top: PRIO_W out of range");
   end

   logic [NUM_IRQ-1:0] cand, active, grant_mask, bcast_vec;
   logic               scan_last, fin_found, accept, grant, bcast;
   logic [IDX_W-1:0]   fin_idx;
   logic [PRIO_W-1:0]  fin_prio;
   ack_kind_e          kind;

   irqarb_state_bank #(.NUM_SPI(NUM_SPI)) u_bank (
      .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_edge(irq_edge),
      .irq_level(irq_level), .spi_target(spi_target), .pend_set(pend_set),
      .pend_clr(pend_clr), .deact(deact), .grant_mask(grant_mask),
      .cand(cand), .active(active)
   );

   irqarb_scan #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .cand(cand), .prio_flat(irq_prio),
      .last(scan_last), .fin_found(fin_found), .fin_idx(fin_idx),
      .fin_prio(fin_prio), .hp_id(hp_id), .hp_prio(hp_prio)
   );

   irqarb_ack_resolve #(.PRIO_W(PRIO_W)) u_resolve (
      .found(fin_found), .grp(irq_group[fin_idx]), .prio(fin_prio),
      .run_prio(run_prio), .cpu_grp_en(cpu_grp_en), .dist_grp_en(dist_grp_en),
      .sec_en(sec_en), .acc_secure(ack_secure), .alias_view(ack_alias),
      .ackctl(ack_ackctl), .kind(kind)
   );

   assign bcast_vec  = {spi_one_of_n, {NUM_PRIV{1'b0}}};
   assign bcast      = bcast_vec[fin_idx];
   assign accept     = scan_last & ack_req;
   assign grant      = accept & (kind == ACK_GRANT);
   assign grant_mask = grant ? ({{(NUM_IRQ-1){1'b0}}, 1'b1} << fin_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_valid <= 1'b0;
         ack_id    <= ID_NONE;
         trk_valid <= 1'b0;
         trk_id    <= ID_NONE;
         trk_prio  <= '1;
         trk_all   <= 1'b0;
      end else begin
         ack_valid <= accept;
         trk_valid <= grant;
         if (accept) begin
            unique case (kind)
               ACK_GRANT:   ack_id <= ID_W'(fin_idx);
               ACK_BLOCKED: ack_id <= ID_BLOCKED;
               default:     ack_id <= ID_NONE;
            endcase
         end
         if (grant) begin
            trk_id   <= ID_W'(fin_idx);
            trk_prio <= fin_prio;
            trk_all  <= bcast;
         end
      end
   end
endmodule

// File: rtl/irqarb_checker.sv
module irqarb_checker
   import irqarb_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int PRIO_W  = 8
)(
   input logic               clk,
   input logic               rst_n,
   input logic               ack_req,
   input logic               ack_valid,
   input logic [ID_W-1:0]    ack_id,
   input logic               trk_valid,
   input logic [ID_W-1:0]    trk_id,
   input logic [PRIO_W-1:0]  trk_prio,
   input logic [PRIO_W-1:0]  run_prio,
   input logic [ID_W-1:0]    hp_id,
   input logic [PRIO_W-1:0]  hp_prio,
   input logic [NUM_IRQ-1:0] active
);
   assert_ack_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(ack_req));

   assert_ack_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> !ack_valid);

   assert_trk_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trk_valid |-> (ack_valid && trk_id == ack_id && ack_id < 10'd1020));

   assert_grant_marks_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trk_valid |-> active[trk_id]);

   assert_grant_beats_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trk_valid |-> (trk_prio < $past(run_prio)));

   assert_idle_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_id == ID_NONE) |-> (hp_prio == '1));
endmodule

bind irqarb_top irqarb_checker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_valid(ack_valid),
   .ack_id(ack_id), .trk_valid(trk_valid), .trk_id(trk_id),
   .trk_prio(trk_prio), .run_prio(run_prio), .hp_id(hp_id),
   .hp_prio(hp_prio), .active(active)
);

// File: tb/tb_irqarb_top.sv
module tb_irqarb_top;
   localparam int NS = 32;
   localparam int NI = NS + 32;
   localparam int PW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NI-1:0] irq_en = '0, irq_edge = '1, irq_group = '0, irq_level = '0;
   logic [NS-1:0] spi_target = '0, spi_one_of_n = '0;
   logic [NI*PW-1:0] irq_prio = '0;
   logic [NI-1:0] pend_set = '0, pend_clr = '0, deact = '0;
   logic [1:0] cpu_grp_en = 2'b11, dist_grp_en = 2'b11;
   logic sec_en = 1'b0, ack_ackctl = 1'b0, ack_req = 1'b0;
   logic ack_alias = 1'b0, ack_secure = 1'b0;
   logic [PW-1:0] run_prio = 8'hFF;
   logic ack_valid, trk_valid, trk_all;
   logic [9:0] ack_id, hp_id, trk_id;
   logic [PW-1:0] hp_prio, trk_prio;

   logic [NI-1:0] m_pend = '0, m_act = '0, m_sig = '0;
   int n_checks = 0, n_errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irqarb_top #(.NUM_SPI(NS), .PRIO_W(PW)) dut (.*);

   task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
      n_checks++;
      if (a !== e) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, a, e);
      end
   endtask

   function automatic logic [9:0] model_expect(input logic al, input logic sc);
      logic [9:0] best = 10'd1023;
      logic [7:0] bp = 8'hFF;
      logic g, ok;
      for (int i = 0; i < NI; i++) begin
         logic p, c;
         p = m_pend[i] | (!irq_edge[i] && irq_level[i] && !m_sig[i]);
         c = irq_en[i] && p && !m_act[i] && (i < 32 || spi_target[i-32]);
         if (c && irq_prio[i*PW +: PW] < bp) begin
            bp = irq_prio[i*PW +: PW];
            best = 10'(i);
         end
      end
      if (best == 10'd1023) return best;
      g = irq_group[best];
      ok = g ? (cpu_grp_en[1] && dist_grp_en[1])
             : (cpu_grp_en[0] && dist_grp_en[0] && (!sec_en || sc));
      if (!ok) return 10'd1023;
      if (!al && g && !ack_ackctl && sec_en && sc) return 10'd1022;
      if (bp >= run_prio) return 10'd1023;
      return best;
   endfunction

   task automatic settle();
      repeat (NI + 4) @(negedge clk);
   endtask

   task automatic pulse(input logic [NI-1:0] s, input logic [NI-1:0] c, input logic [NI-1:0] d);
      @(negedge clk);
      pend_set = s; pend_clr = c; deact = d;
      @(negedge clk);
      pend_set = '0; pend_clr = '0; deact = '0;
      m_pend = (m_pend & ~c) | s;
      m_act  = m_act & ~d;
      m_sig  = m_sig & ~d;
   endtask

   task automatic ack_check(input logic al, input logic sc, input logic [9:0] exp_id, input string tag);
      logic grant;
      logic exp_all;
      settle();
      grant = (exp_id < 10'd1020);
      ack_alias = al; ack_secure = sc; ack_req = 1'b1;
      @(negedge clk);
      while (!ack_valid) @(negedge clk);
      ack_req = 1'b0;
      chk({tag, " ack_id"}, 32'(ack_id), 32'(exp_id));
      chk({tag, " trk_valid"}, 32'(trk_valid), 32'(grant));
      if (grant) begin
         exp_all = (exp_id >= 10'd32) ? spi_one_of_n[exp_id-10'd32] : 1'b0;
         chk({tag, " trk_id"}, 32'(trk_id), 32'(exp_id));
         chk({tag, " trk_prio"}, 32'(trk_prio), 32'(irq_prio[exp_id*PW +: PW]));
         chk({tag, " trk_all"}, 32'(trk_all), 32'(exp_all));
         m_act[exp_id] = 1'b1; m_sig[exp_id] = 1'b1; m_pend[exp_id] = 1'b0;
      end
      @(negedge clk);
      chk({tag, " ack_valid one cycle"}, 32'(ack_valid), 32'd0);
   endtask

   function automatic logic [NI-1:0] one(input int i);
      return {{(NI-1){1'b0}}, 1'b1} << i;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : stim
      int unsigned seed_v;
      seed_v = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      chk("R12 ack_valid in reset", 32'(ack_valid), 32'd0);
      rst_n = 1'b1;
      settle();
      chk("R12 hp_id after reset", 32'(hp_id), 32'd1023);
      chk("R12 hp_prio after reset", 32'(hp_prio), 32'hFF);
      chk("R12 trk_valid after reset", 32'(trk_valid), 32'd0);
      ack_check(0, 0, 10'd1023, "R4 empty");

      // R4 tie to lowest id, R2 active excluded, R9 all flag
      irq_prio[5*PW +: PW] = 8'h40; irq_prio[40*PW +: PW] = 8'h40;
      irq_en[5] = 1; irq_en[40] = 1; spi_target[8] = 1; spi_one_of_n[8] = 1;
      pulse(one(5) | one(40), '0, '0);
      settle();
      chk("R4 hp_id tie", 32'(hp_id), 32'd5);
      chk("R4 hp_prio tie", 32'(hp_prio), 32'h40);
      ack_check(0, 0, 10'd5, "R4 tie lowest id");
      ack_check(0, 0, 10'd40, "R2 active skipped");
      pulse('0, '0, one(5) | one(40));
      ack_check(0, 0, 10'd1023, "R8 pending latch cleared by grant");

      // R1 target bit
      irq_prio[45*PW +: PW] = 8'h10; irq_prio[7*PW +: PW] = 8'h80;
      irq_en[45] = 1; irq_en[7] = 1;
      pulse(one(45) | one(7), '0, '0);
      ack_check(0, 0, 10'd7, "R1 untargeted shared skipped");
      pulse('0, '0, one(7));
      spi_target[13] = 1;
      ack_check(0, 0, 10'd45, "R1 targeted shared wins");
      pulse('0, '0, one(45));

      // R4 all-ones priority; R11 clear, set wins
      irq_prio[3*PW +: PW] = 8'hFF; irq_en[3] = 1;
      pulse(one(3), '0, '0);
      ack_check(0, 0, 10'd1023, "R4 all-ones priority never wins");
      irq_prio[3*PW +: PW] = 8'h20;
      pulse('0, one(3), '0);
      ack_check(0, 0, 10'd1023, "R11 pend_clr");
      irq_prio[12*PW +: PW] = 8'h22; irq_en[12] = 1;
      pulse(one(12), one(12), '0);
      ack_check(0, 0, 10'd12, "R11 set beats clr");
      pulse('0, '0, one(12));

      // R3 level mode
      irq_prio[20*PW +: PW] = 8'h30; irq_en[20] = 1; irq_edge[20] = 0; irq_level[20] = 1;
      irq_prio[21*PW +: PW] = 8'h08; irq_en[21] = 1; irq_level[21] = 1;
      ack_check(0, 0, 10'd20, "R3 level pending, edge level ignored");
      ack_check(0, 0, 10'd1023, "R3 signalled level not pending");
      pulse('0, '0, one(20));
      ack_check(0, 0, 10'd20, "R3 level re-pends after deact");
      pulse('0, '0, one(20));
      irq_level[20] = 0; irq_level[21] = 0;
      ack_check(0, 0, 10'd1023, "R3 level low");

      // R7 running priority
      irq_prio[9*PW +: PW] = 8'h50; irq_en[9] = 1;
      pulse(one(9), '0, '0);
      run_prio = 8'h50;
      ack_check(0, 0, 10'd1023, "R7 equal running priority");
      run_prio = 8'h51;
      ack_check(0, 0, 10'd9, "R7 higher than running");
      pulse('0, '0, one(9));
      run_prio = 8'hFF;

      // R5 / R6 groups and security
      irq_prio[10*PW +: PW] = 8'h20; irq_en[10] = 1; irq_group[10] = 1;
      pulse(one(10), '0, '0);
      cpu_grp_en = 2'b01;
      ack_check(0, 0, 10'd1023, "R5 cpu group1 disabled");
      cpu_grp_en = 2'b11; dist_grp_en = 2'b01;
      ack_check(0, 0, 10'd1023, "R5 dist group1 disabled");
      dist_grp_en = 2'b11; sec_en = 1;
      ack_check(0, 1, 10'd1022, "R6 secure non-alias group1");
      ack_ackctl = 1;
      ack_check(0, 1, 10'd10, "R6 ackctl allows");
      pulse(one(10), '0, one(10));
      ack_ackctl = 0;
      ack_check(1, 1, 10'd10, "R6 alias allows");
      pulse('0, '0, one(10));
      irq_prio[11*PW +: PW] = 8'h20; irq_en[11] = 1;
      pulse(one(11), '0, '0);
      ack_check(0, 0, 10'd1023, "R5 group0 nonsecure");
      ack_check(0, 1, 10'd11, "R5 group0 secure");
      pulse('0, '0, one(11));
      sec_en = 0;

      // constrained random mixed with the above
      for (int it = 0; it < 60; it++) begin
         logic [NI-1:0] sv = '0;
         logic al, sc;
         for (int k = 0; k < 4; k++) begin
            int id;
            id = int'($urandom_range(NI-1, 0));
            irq_en[id] = 1'b1;
            irq_prio[id*PW +: PW] = 8'($urandom_range(15, 0)) << 4;
            irq_edge[id] = 1'($urandom);
            irq_level[id] = 1'($urandom);
            irq_group[id] = 1'($urandom);
            if ($urandom_range(1, 0) == 1) sv[id] = 1'b1;
         end
         spi_target = spi_target | NS'($urandom);
         spi_one_of_n = NS'($urandom);
         sec_en = 1'($urandom);
         ack_ackctl = 1'($urandom);
         run_prio = ($urandom_range(3, 0) == 0) ? 8'h80 : 8'hFF;
         al = 1'($urandom); sc = 1'($urandom);
         pulse(sv, '0, ($urandom_range(1, 0) == 1) ? m_act : '0);
         ack_check(al, sc, model_expect(al, sc), "R2 R4 R5 R6 R7 R8 R9 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule